// File: doc/BRIEF.md
# MMU Translation Fault Classifier

This block sits behind an address translation unit and judges the result of one translation attempt. Each attempt is either an instruction fetch or a data load/store. The translation unit reports several things: whether a block-map entry matched, whether a page table entry was found, the guarded bits of each, the block and page protection verdicts, and the segment's no-execute and direct-store flags. The classifier decides whether a memory-management fault follows. If one does, it raises an instruction-fault or a data-fault request and a 32-bit cause word.

Cause bits use big-endian numbering, so cause bit n is vector index 31-n of the word. A block-map hit outranks the page result, which means a block hit hides any page miss or page protection verdict. Several causes can be set in the same word. A fault is captured on a valid strobe and held until it is acknowledged. While a fault is held, further attempts are dropped.

Top module: `xlat_fault_classifier`

## Requirements
- R1: After reset, ifault_req and dfault_req are 0 and fault_status is all zeros.
- R2: With translation enabled for the access type, the page-miss cause applies when neither blk_hit nor pg_hit is set. It sets cause bit 1 (index 30), with ifault_req for a fetch (is_fetch=1) or dfault_req for a load/store (is_fetch=0).
- R3: With translation enabled, cause bit 4 (index 27) is set in either of two cases. The first is blk_hit=1 and blk_viol=1. The second is blk_hit=0, pg_hit=1 and pg_viol=1.
- R4: A fetch with itrans_on=1 and seg_noexec=1 or seg_direct=1 raises ifault_req with cause bit 3 (index 28).
- R5: A load/store with dtrans_on=1 and seg_direct=1 raises dfault_req with cause bit 5 (index 26).
- R6: A fetch with itrans_on=1 sets cause bit 3 when the effective guarded bit is 1. That bit is blk_guard when blk_hit=1, and otherwise pg_hit AND pg_guard.
- R7: A fetch with itrans_on=0, or a load/store with dtrans_on=0, raises no fault and leaves the outputs at 0.
- R8: When blk_hit=1, the page-miss bit and the page-protection cause are never set.
- R9: An attempt is taken on req_valid while no fault is pending. Its result appears one clock later and then stays unchanged until fault_ack. fault_ack clears both requests and the word one clock later. req_valid is ignored while a fault is pending, including in the cycle fault_ack is high.
- R10: All applicable causes are merged into one word. An attempt with no cause leaves nothing pending.
- R11: At most one of ifault_req and dfault_req is high. fault_status is nonzero exactly when one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation result is presented this cycle |
| is_fetch | input | 1 | 1 = instruction fetch, 0 = load/store |
| itrans_on | input | 1 | Instruction translation enabled |
| dtrans_on | input | 1 | Data translation enabled |
| seg_noexec | input | 1 | Segment forbids execution |
| seg_direct | input | 1 | Segment is a direct-store segment |
| blk_hit | input | 1 | A block-map entry matched |
| blk_guard | input | 1 | Guarded bit of the matching block entry |
| blk_viol | input | 1 | Block protection check failed |
| pg_hit | input | 1 | A page table entry was found |
| pg_guard | input | 1 | Guarded bit of the page entry |
| pg_viol | input | 1 | Page protection check failed |
| fault_ack | input | 1 | Pending fault has been handled |
| ifault_req | output | 1 | Instruction fault pending |
| dfault_req | output | 1 | Data fault pending |
| fault_status | output | 32 | Cause word, big-endian bit numbering |

## Verification
The acknowledge of a held fault and the arrival of a new attempt can fall in the same cycle. The bench first latches a fault, then offers conflicting attempts for several cycles while checking that the word does not move. Next it raises fault_ack and req_valid together and expects a cleared output in the following cycle, which shows that the colliding attempt was dropped. The same situation arises inside the classification logic, where the no-execute, direct-store and guarded causes share bit 3 and miss, protection and direct-store causes meet in one word. The exhaustive sweep of all 2048 input combinations judges every such overlap against an arithmetic model.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    // One translation attempt as seen by the classifier
    typedef struct packed {
        logic fetch;
        logic itr_en;
        logic dtr_en;
        logic seg_nx;
        logic seg_ds;
        logic blk_hit;
        logic blk_grd;
        logic blk_viol;
        logic pg_hit;
        logic pg_grd;
        logic pg_viol;
    } xlat_info_t;

    typedef enum logic [1:0] {
        FK_NONE  = 2'b00,
        FK_INSTR = 2'b01,
        FK_DATA  = 2'b10
    } fault_kind_t;

    // Resolved translation result after block/page precedence
    typedef struct packed {
        logic miss;
        logic prot;
        logic guard;
    } resolved_t;
endpackage

// File: rtl/xfc_resolve.sv
module xfc_resolve
    import xfc_pkg::*;
(
    input  xlat_info_t info,
    output resolved_t  res
);
    // Block-map hit outranks whatever the page lookup returned
    always_comb begin
        res.miss = !info.blk_hit && !info.pg_hit;
        if (info.blk_hit) begin
            res.prot  = info.blk_viol;
            res.guard = info.blk_grd;
        end else begin
            res.prot  = info.pg_hit && info.pg_viol;
            res.guard = info.pg_hit && info.pg_grd;
        end
    end
endmodule

// File: rtl/xfc_encode.sv
module xfc_encode
    import xfc_pkg::*;
#(
    parameter int unsigned STATUS_W = 32,
    parameter int unsigned MISS_BIT = 1,
    parameter int unsigned EXEC_BIT = 3,
    parameter int unsigned PROT_BIT = 4,
    parameter int unsigned DSEG_BIT = 5
) (
    input  xlat_info_t          info,
    input  resolved_t           res,
    output logic [STATUS_W-1:0] word,
    output fault_kind_t         kind
);
    // Big-endian numbering: cause bit n lives at index STATUS_W-1-n
    localparam int unsigned MISS_IDX = STATUS_W - 1 - MISS_BIT;
    localparam int unsigned EXEC_IDX = STATUS_W - 1 - EXEC_BIT;
    localparam int unsigned PROT_IDX = STATUS_W - 1 - PROT_BIT;
    localparam int unsigned DSEG_IDX = STATUS_W - 1 - DSEG_BIT;

    logic gate_i, gate_d;
    logic miss_c, prot_c, exec_c, dseg_c;

    always_comb begin
        gate_i = info.fetch && info.itr_en;
        gate_d = !info.fetch && info.dtr_en;
        miss_c = (gate_i || gate_d) && res.miss;
        prot_c = (gate_i || gate_d) && res.prot;
        exec_c = gate_i && (info.seg_nx || info.seg_ds || res.guard);
        dseg_c = gate_d && info.seg_ds;
    end

    for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
        if (i == MISS_IDX) begin : g_miss
            assign word[i] = miss_c;
        end else if (i == EXEC_IDX) begin : g_exec
            assign word[i] = exec_c;
        end else if (i == PROT_IDX) begin : g_prot
            assign word[i] = prot_c;
        end else if (i == DSEG_IDX) begin : g_dseg
            assign word[i] = dseg_c;
        end else begin : g_zero
            assign word[i] = 1'b0;
        end
    end

    always_comb begin
        if (word == '0)      kind = FK_NONE;
        else if (info.fetch) kind = FK_INSTR;
        else                 kind = FK_DATA;
    end
endmodule

// File: rtl/xlat_fault_classifier.sv
module xlat_fault_classifier
    import xfc_pkg::*;
#(
    parameter int unsigned STATUS_W = 32,
    parameter int unsigned MISS_BIT = 1,
    parameter int unsigned EXEC_BIT = 3,
    parameter int unsigned PROT_BIT = 4,
    parameter int unsigned DSEG_BIT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                is_fetch,
    input  logic                itrans_on,
    input  logic                dtrans_on,
    input  logic                seg_noexec,
    input  logic                seg_direct,
    input  logic                blk_hit,
    input  logic                blk_guard,
    input  logic                blk_viol,
    input  logic                pg_hit,
    input  logic                pg_guard,
    input  logic                pg_viol,
    input  logic                fault_ack,
    output logic                ifault_req,
    output logic                dfault_req,
    output logic [STATUS_W-1:0] fault_status
);
    typedef struct packed {
        fault_kind_t         kind;
        logic [STATUS_W-1:0] word;
    } hold_t;

    xlat_info_t          info;
    resolved_t           res;
    logic [STATUS_W-1:0] cause_word;
    fault_kind_t         cause_kind;
    hold_t               st_d, st_q;
    logic                pending;

    always_comb begin
        info.fetch    = is_fetch;
        info.itr_en   = itrans_on;
        info.dtr_en   = dtrans_on;
        info.seg_nx   = seg_noexec;
        info.seg_ds   = seg_direct;
        info.blk_hit  = blk_hit;
        info.blk_grd  = blk_guard;
        info.blk_viol = blk_viol;
        info.pg_hit   = pg_hit;
        info.pg_grd   = pg_guard;
        info.pg_viol  = pg_viol;
    end

    xfc_resolve u_resolve (
        .info (info),
        .res  (res)
    );

    xfc_encode #(
        .STATUS_W (STATUS_W),
        .MISS_BIT (MISS_BIT),
        .EXEC_BIT (EXEC_BIT),
        .PROT_BIT (PROT_BIT),
        .DSEG_BIT (DSEG_BIT)
    ) u_encode (
        .info (info),
        .res  (res),
        .word (cause_word),
        .kind (cause_kind)
    );

    assign pending = (st_q.kind != FK_NONE);

    always_comb begin
        st_d = st_q;
        if (pending) begin
            if (fault_ack) begin
                st_d.kind = FK_NONE;
                st_d.word = '0;
            end
        end else if (req_valid && cause_kind != FK_NONE) begin
            st_d.kind = cause_kind;
            st_d.word = cause_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.kind <= FK_NONE;
            st_q.word <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ifault_req   = (st_q.kind == FK_INSTR);
    assign dfault_req   = (st_q.kind == FK_DATA);
    assign fault_status = st_q.word;
endmodule

// File: rtl/xlat_fault_classifier_chk.sv
module xlat_fault_classifier_chk #(
    parameter int unsigned STATUS_W = 32,
    parameter int unsigned EXEC_BIT = 3,
    parameter int unsigned MISS_BIT = 1,
    parameter int unsigned DSEG_BIT = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                fault_ack,
    input logic                is_fetch,
    input logic                itrans_on,
    input logic                dtrans_on,
    input logic                seg_noexec,
    input logic                seg_direct,
    input logic                blk_hit,
    input logic                ifault_req,
    input logic                dfault_req,
    input logic [STATUS_W-1:0] fault_status
);
    localparam int unsigned EXEC_IDX = STATUS_W - 1 - EXEC_BIT;
    localparam int unsigned MISS_IDX = STATUS_W - 1 - MISS_BIT;
    localparam int unsigned DSEG_IDX = STATUS_W - 1 - DSEG_BIT;

    logic busy;
    assign busy = ifault_req || dfault_req;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fault_ack |=> $stable(fault_status) && $stable(ifault_req) && $stable(dfault_req));

    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && fault_ack |=> !ifault_req && !dfault_req && fault_status == '0);

    assert_one_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ifault_req, dfault_req}) <= 1);

    assert_word_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (fault_status != '0));

    assert_fetch_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && is_fetch && !itrans_on |=> !busy);

    assert_data_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && !is_fetch && !dtrans_on |=> !busy);

    assert_noexec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && is_fetch && itrans_on && (seg_noexec || seg_direct)
        |=> ifault_req && fault_status[EXEC_IDX]);

    assert_dseg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && !is_fetch && dtrans_on && seg_direct
        |=> dfault_req && fault_status[DSEG_IDX]);

    assert_blk_no_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_valid && blk_hit |=> !fault_status[MISS_IDX]);
endmodule

bind xlat_fault_classifier xlat_fault_classifier_chk #(
    .STATUS_W (STATUS_W),
    .EXEC_BIT (EXEC_BIT),
    .MISS_BIT (MISS_BIT),
    .DSEG_BIT (DSEG_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .fault_ack    (fault_ack),
    .is_fetch     (is_fetch),
    .itrans_on    (itrans_on),
    .dtrans_on    (dtrans_on),
    .seg_noexec   (seg_noexec),
    .seg_direct   (seg_direct),
    .blk_hit      (blk_hit),
    .ifault_req   (ifault_req),
    .dfault_req   (dfault_req),
    .fault_status (fault_status)
);

// File: tb/xlat_fault_classifier_bench.sv
module xlat_fault_classifier_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        is_fetch = 1'b0, itrans_on = 1'b0, dtrans_on = 1'b0;
    logic        seg_noexec = 1'b0, seg_direct = 1'b0;
    logic        blk_hit = 1'b0, blk_guard = 1'b0, blk_viol = 1'b0;
    logic        pg_hit = 1'b0, pg_guard = 1'b0, pg_viol = 1'b0;
    logic        fault_ack = 1'b0;
    logic        ifault_req, dfault_req;
    logic [31:0] fault_status;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    xlat_fault_classifier u_xlat_fault_classifier (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .is_fetch(is_fetch), .itrans_on(itrans_on), .dtrans_on(dtrans_on),
        .seg_noexec(seg_noexec), .seg_direct(seg_direct),
        .blk_hit(blk_hit), .blk_guard(blk_guard), .blk_viol(blk_viol),
        .pg_hit(pg_hit), .pg_guard(pg_guard), .pg_viol(pg_viol),
        .fault_ack(fault_ack), .ifault_req(ifault_req), .dfault_req(dfault_req),
        .fault_status(fault_status)
    );

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_vec(input logic [10:0] v);
        {is_fetch, itrans_on, dtrans_on, seg_noexec, seg_direct,
         blk_hit, blk_guard, blk_viol, pg_hit, pg_guard, pg_viol} = v;
    endtask

    // Arithmetic model: cause bit n weighs 2**(31-n)
    function automatic logic [33:0] model(input logic [10:0] v, output string tag);
        logic f, ie, de, nx, ds, bh, bg, bv, ph, pgd, pv;
        logic [31:0] w;
        bit on;
        {f, ie, de, nx, ds, bh, bg, bv, ph, pgd, pv} = v;
        w = 32'd0;
        on = f ? bit'(ie) : bit'(de);
        tag = "R7 translation off";
        if (on) begin
            tag = "R10 merged causes";
            if (!bh && !ph) begin w = w + (32'd1 << (31 - 1)); tag = "R2 page miss"; end
            if ((bh && bv) || (!bh && ph && pv)) w = w + (32'd1 << (31 - 4));
            if (f && (nx || ds || (bh ? bg : (ph && pgd)))) begin
                w = w + (32'd1 << (31 - 3));
                if (!nx && !ds) tag = "R6 guarded fetch"; else tag = "R4 exec segment";
            end
            if (!f && ds) begin w = w + (32'd1 << (31 - 5)); tag = "R5 data direct segment"; end
            if (bh) tag = "R8 block precedence R3";
        end
        return {w != 0 && f, w != 0 && !f, w};
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [33:0] exp;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", {ifault_req, dfault_req, fault_status}, 34'd0);

        // Exhaustive sweep of every input combination
        for (int v = 0; v < 2048; v++) begin
            exp = model(11'(v), tag);
            set_vec(11'(v));
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check(tag, {ifault_req, dfault_req, fault_status}, exp);
            if (exp[31:0] == 32'd0)
                check("R10 no cause leaves idle", {ifault_req, dfault_req, fault_status}, 34'd0);
            if (exp[33] | exp[32]) begin
                fault_ack = 1'b1;
                @(negedge clk);
                fault_ack = 1'b0;
                check("R9 ack clears", {ifault_req, dfault_req, fault_status}, 34'd0);
            end
        end

        // Hold while pending, ignore new attempts
        set_vec(11'b11000000000);   // fetch, page miss -> bit 1
        req_valid = 1'b1;
        @(negedge clk);
        exp = {2'b10, 32'h4000_0000};
        check("R2 fetch miss latched", {ifault_req, dfault_req, fault_status}, exp);
        set_vec(11'b00101000000);   // data direct segment + miss
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 held while pending", {ifault_req, dfault_req, fault_status}, exp);
        end
        fault_ack = 1'b1;           // ack and valid in the same cycle
        @(negedge clk);
        fault_ack = 1'b0;
        req_valid = 1'b0;
        check("R9 valid dropped at ack", {ifault_req, dfault_req, fault_status}, 34'd0);
        @(negedge clk);
        check("R11 stays idle", {ifault_req, dfault_req, fault_status}, 34'd0);

        // Ack with nothing pending has no effect; a later attempt still latches
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        check("R9 idle ack no effect", {ifault_req, dfault_req, fault_status}, 34'd0);
        set_vec(11'b00101000000);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 data direct with miss", {ifault_req, dfault_req, fault_status},
              {2'b01, 32'h4000_0000 | 32'h0400_0000});

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule